// File: doc/BRIEF.md
# I2C Master Control Register

This block is the control register that an I2C controller's bus engine reads to learn what transfer to run next. It stores the target address and its addressing mode, the transfer direction, the byte count, the reload and automatic-end modes, and four request flags: start, stop, not-acknowledge and packet-error-check byte. Software writes the register through a simple write port with per-byte enables. The engine reports events such as "address sent", "stop seen" or "arbitration lost" on single-cycle pulse inputs, and these clear the matching request flags.

The request flags can only be raised by software. Writing a zero to one of them does nothing. Each flag is lowered only by its own set of hardware events. While a start request is pending, the transfer description (address, direction, addressing mode, header-only mode and byte count) is frozen, so the engine never sees it change partway through an address phase. The block also presents some decoded values to the engine: the target address normalised to its addressing mode, and the start, packet-error-check and automatic-end controls with the reload mode already taken into account.

Top module: `i2c_mctl_reg`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0x00000000 and every output that goes to the engine is 0.
- R2: The layout of `rd_data` is: address [9:0], read direction [10], 10-bit mode [11], header-only [12], start [13], stop [14], nack [15], byte count [23:16], reload [24], auto-end [25], pec [26]. Bits [31:27] always read 0. A write changes only the bytes whose `wr_be` bit is set, and it takes effect on the next clock edge.
- R3: Writing 0 to start, stop, nack or pec leaves the stored bit unchanged. Writing 1 to one of them sets it.
- R4: Start is cleared by any of these: `evt_addr_sent`, `evt_arb_lost`, `evt_timeout`, `evt_addr_clr`, or `periph_en` low.
- R5: Nack and pec are each cleared by their own sent event (`evt_nack_sent`, `evt_pec_sent`). Both are also cleared by `evt_stop_rx`, by `evt_addr_match`, or by `periph_en` low.
- R6: Stop is cleared by `evt_stop_rx` or by `periph_en` low.
- R7: When a clear event and a software write of 1 reach the same request bit in the same cycle, the bit ends up 0.
- R8: While the stored start bit is 1, writes to the address, read direction, 10-bit mode, header-only and byte-count fields are ignored. Writes to all other fields still take effect.
- R9: `tgt_addr` equals the full 10-bit address when 10-bit mode is set. Otherwise it equals {3'b000, address[7:1]}, which ignores address bits 9, 8 and 0.
- R10: While reload is 1, `start_go`, `pec_go` and `autoend_eff` are 0, even if the stored bits are 1. While reload is 0, these outputs follow the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| periph_en | input | 1 | Peripheral enable; when low, all request bits are cleared |
| evt_addr_sent | input | 1 | Start condition and address have been sent |
| evt_arb_lost | input | 1 | Arbitration was lost |
| evt_timeout | input | 1 | Bus timeout was detected |
| evt_addr_clr | input | 1 | Software write to the address-match clear flag |
| evt_nack_sent | input | 1 | A NACK has gone out |
| evt_pec_sent | input | 1 | The PEC byte has gone out |
| evt_stop_rx | input | 1 | A STOP condition was detected |
| evt_addr_match | input | 1 | An own-address match was received |
| rd_data | output | 32 | Current register contents |
| tgt_addr | output | 10 | Target address normalised to the addressing mode |
| xfer_rd | output | 1 | Transfer direction (1 = read) |
| addr10 | output | 1 | 10-bit addressing mode |
| head10r_only | output | 1 | Send only the 10-bit header for a read |
| nbytes | output | 8 | Byte count |
| reload | output | 1 | Byte-count reload mode |
| autoend_eff | output | 1 | Automatic end, masked by reload |
| start_go | output | 1 | Start request, masked by reload |
| stop_req | output | 1 | Stop request |
| nack_req | output | 1 | NACK request |
| pec_go | output | 1 | PEC byte request, masked by reload |

## Verification
A software write and a hardware clear can hit the same request bit in the same cycle. This is provoked by driving a write of 1 to start together with an arbitration-loss pulse, and a write of 1 to nack together with an address-match pulse. The result is judged correct if the bit reads 0 afterwards. The lock can likewise coincide with a write: the bench writes the address and byte count while start is pending and expects the old values on `rd_data`.

// File: rtl/i2c_mctl_pkg.sv
// Package: bit positions and widths of the I2C master control register.
// Assumes a 32-bit register whose layout is fixed, because the bus engine
// decodes these fields.
package i2c_mctl_pkg;
    localparam int REG_W       = 32;
    localparam int BE_W        = REG_W / 8;
    localparam int ADDR_W      = 10;
    localparam int CNT_W       = 8;
    localparam int POS_ADDR    = 0;
    localparam int POS_RD      = 10;
    localparam int POS_A10     = 11;
    localparam int POS_H10     = 12;
    localparam int POS_START   = 13;
    localparam int POS_STOP    = 14;
    localparam int POS_NACK    = 15;
    localparam int POS_CNT     = 16;
    localparam int POS_RELOAD  = 24;
    localparam int POS_AUTOEND = 25;
    localparam int POS_PEC     = 26;
    localparam int NUM_REQ     = 4;

    // Request flags, in index order.
    typedef enum logic [1:0] {
        REQ_START = 2'd0,
        REQ_STOP  = 2'd1,
        REQ_NACK  = 2'd2,
        REQ_PEC   = 2'd3
    } req_idx_e;

    // Bit position of request flag idx inside the register.
    function automatic int req_pos(input int idx);
        case (idx)
            0:       return POS_START;
            1:       return POS_STOP;
            2:       return POS_NACK;
            default: return POS_PEC;
        endcase
    endfunction
endpackage

// File: rtl/i2c_mctl_field.sv
// Module: one software-written configuration field of width W at bit POS.
// Each bit takes its byte enable from the byte it falls in, so a field may
// span two bytes. When lock is high, writes are ignored.
module i2c_mctl_field
    import i2c_mctl_pkg::*;
#(
    parameter int W   = 1,
    parameter int POS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock,
    output logic [W-1:0]     q
);
    logic [W-1:0] bit_we;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int BYTE_IDX = (POS + i) / 8;
        // Per-bit write enable built from the enable of its byte.
        assign bit_we[i] = wr_en && wr_be[BYTE_IDX] && !lock;

        // Store the bit: load it on an enabled write, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (bit_we[i]) q[i] <= wr_data[POS + i];
        end
    end
endmodule

// File: rtl/i2c_mctl_req.sv
// Module: one request flag that software can only set and hardware clears.
// When set and clr arrive in the same cycle, clr wins.
module i2c_mctl_req (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag update: clear has priority, then set, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end
endmodule

// File: rtl/i2c_mctl_reg.sv
// Module: I2C master control register. It stores the transfer description
// and the request flags, freezes the description while start is pending,
// and clears the flags on engine events. Assumes the event inputs are
// single-cycle pulses that are synchronous to clk.
module i2c_mctl_reg
    import i2c_mctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [BE_W-1:0]    wr_be,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               periph_en,
    input  logic               evt_addr_sent,
    input  logic               evt_arb_lost,
    input  logic               evt_timeout,
    input  logic               evt_addr_clr,
    input  logic               evt_nack_sent,
    input  logic               evt_pec_sent,
    input  logic               evt_stop_rx,
    input  logic               evt_addr_match,
    output logic [REG_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]  tgt_addr,
    output logic               xfer_rd,
    output logic               addr10,
    output logic               head10r_only,
    output logic [CNT_W-1:0]   nbytes,
    output logic               reload,
    output logic               autoend_eff,
    output logic               start_go,
    output logic               stop_req,
    output logic               nack_req,
    output logic               pec_go
);
    logic [ADDR_W-1:0]  addr_q;
    logic               rd_q, a10_q, h10_q, reload_q, autoend_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_REQ-1:0] req_q, req_set, req_clr;
    logic               desc_lock;

    // The transfer description is frozen while start is pending.
    assign desc_lock = req_q[REQ_START];

    i2c_mctl_field #(.W(ADDR_W), .POS(POS_ADDR)) u_addr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(desc_lock), .q(addr_q));
    i2c_mctl_field #(.W(1), .POS(POS_RD)) u_rd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(desc_lock), .q(rd_q));
    i2c_mctl_field #(.W(1), .POS(POS_A10)) u_a10 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(desc_lock), .q(a10_q));
    i2c_mctl_field #(.W(1), .POS(POS_H10)) u_h10 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(desc_lock), .q(h10_q));
    i2c_mctl_field #(.W(CNT_W), .POS(POS_CNT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(desc_lock), .q(cnt_q));
    i2c_mctl_field #(.W(1), .POS(POS_RELOAD)) u_reload (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(1'b0), .q(reload_q));
    i2c_mctl_field #(.W(1), .POS(POS_AUTOEND)) u_autoend (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .lock(1'b0), .q(autoend_q));

    // Clear sources for each request flag.
    always_comb begin
        req_clr[REQ_START] = !periph_en || evt_addr_sent || evt_arb_lost
                             || evt_timeout || evt_addr_clr;
        req_clr[REQ_STOP]  = !periph_en || evt_stop_rx;
        req_clr[REQ_NACK]  = !periph_en || evt_nack_sent || evt_stop_rx
                             || evt_addr_match;
        req_clr[REQ_PEC]   = !periph_en || evt_pec_sent || evt_stop_rx
                             || evt_addr_match;
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        localparam int RPOS = req_pos(r);
        // Software sets a flag only by writing 1 to its bit.
        assign req_set[r] = wr_en && wr_be[RPOS / 8] && wr_data[RPOS];
        i2c_mctl_req u_req (
            .clk(clk), .rst_n(rst_n), .set(req_set[r]),
            .clr(req_clr[r]), .q(req_q[r]));
    end

    // Read-back view: fields at their positions, reserved bits zero.
    always_comb begin
        rd_data = '0;
        rd_data[POS_ADDR +: ADDR_W] = addr_q;
        rd_data[POS_RD]             = rd_q;
        rd_data[POS_A10]            = a10_q;
        rd_data[POS_H10]            = h10_q;
        rd_data[POS_START]          = req_q[REQ_START];
        rd_data[POS_STOP]           = req_q[REQ_STOP];
        rd_data[POS_NACK]           = req_q[REQ_NACK];
        rd_data[POS_CNT +: CNT_W]   = cnt_q;
        rd_data[POS_RELOAD]         = reload_q;
        rd_data[POS_AUTOEND]        = autoend_q;
        rd_data[POS_PEC]            = req_q[REQ_PEC];
    end

    // Engine view: normalised address and reload-masked controls.
    always_comb begin
        tgt_addr     = a10_q ? addr_q : {3'b000, addr_q[7:1]};
        xfer_rd      = rd_q;
        addr10       = a10_q;
        head10r_only = h10_q;
        nbytes       = cnt_q;
        reload       = reload_q;
        autoend_eff  = autoend_q && !reload_q;
        start_go     = req_q[REQ_START] && !reload_q;
        stop_req     = req_q[REQ_STOP];
        nack_req     = req_q[REQ_NACK];
        pec_go       = req_q[REQ_PEC] && !reload_q;
    end
endmodule

// File: rtl/i2c_mctl_reg_chk.sv
// Module: assertion checker for i2c_mctl_reg, attached through bind.
// It observes only the ports of the top module.
module i2c_mctl_reg_chk
    import i2c_mctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [BE_W-1:0]    wr_be,
    input logic [REG_W-1:0]   wr_data,
    input logic               periph_en,
    input logic               evt_addr_sent,
    input logic               evt_arb_lost,
    input logic               evt_timeout,
    input logic               evt_addr_clr,
    input logic               evt_nack_sent,
    input logic               evt_pec_sent,
    input logic               evt_stop_rx,
    input logic               evt_addr_match,
    input logic [REG_W-1:0]   rd_data,
    input logic [ADDR_W-1:0]  tgt_addr,
    input logic               reload,
    input logic               autoend_eff,
    input logic               start_go,
    input logic               pec_go
);
    // R2: reserved bits never read as 1.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:POS_PEC+1] == '0);

    // R3: a set start flag stays set when no clear event is present.
    a_r3_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[POS_START] && periph_en && !evt_addr_sent && !evt_arb_lost
         && !evt_timeout && !evt_addr_clr) |=> rd_data[POS_START]);

    // R4, R7: any start clear event leaves start low, even with a set.
    a_r4_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_en || evt_addr_sent || evt_arb_lost || evt_timeout
         || evt_addr_clr) |=> !rd_data[POS_START]);

    // R5, R7: nack and pec drop on stop received or address match.
    a_r5_nack_pec_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop_rx || evt_addr_match || !periph_en)
        |=> (!rd_data[POS_NACK] && !rd_data[POS_PEC]));

    // R6: stop drops after a stop condition is detected.
    a_r6_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop_rx || !periph_en) |=> !rd_data[POS_STOP]);

    // R8: the locked description is stable while start is pending.
    a_r8_lock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[POS_START] |=> ($stable(rd_data[POS_H10:0])
                                && $stable(rd_data[POS_CNT +: CNT_W])));

    // R9: in 7-bit mode the target address comes from bits [7:1].
    a_r9_addr7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[POS_A10] |-> (tgt_addr == {3'b000, rd_data[7:1]}));

    // R10: reload masks start, pec and auto-end toward the engine.
    a_r10_reload_mask: assert property (@(posedge clk) disable iff (!rst_n)
        reload |-> (!start_go && !pec_go && !autoend_eff));
endmodule

bind i2c_mctl_reg i2c_mctl_reg_chk u_chk (.*);

// File: tb/i2c_mctl_reg_bench.sv
// Bench: walks a table of writes with expected read-back values, then runs
// directed tests for reset, clear events, same-cycle races and masking.
module i2c_mctl_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        periph_en = 1'b1;
    logic        evt_addr_sent = 1'b0, evt_arb_lost = 1'b0, evt_timeout = 1'b0;
    logic        evt_addr_clr = 1'b0, evt_nack_sent = 1'b0, evt_pec_sent = 1'b0;
    logic        evt_stop_rx = 1'b0, evt_addr_match = 1'b0;
    logic [31:0] rd_data;
    logic [9:0]  tgt_addr;
    logic        xfer_rd, addr10, head10r_only, reload, autoend_eff;
    logic        start_go, stop_req, nack_req, pec_go;
    logic [7:0]  nbytes;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mctl_reg u_i2c_mctl_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .periph_en(periph_en),
        .evt_addr_sent(evt_addr_sent), .evt_arb_lost(evt_arb_lost),
        .evt_timeout(evt_timeout), .evt_addr_clr(evt_addr_clr),
        .evt_nack_sent(evt_nack_sent), .evt_pec_sent(evt_pec_sent),
        .evt_stop_rx(evt_stop_rx), .evt_addr_match(evt_addr_match),
        .rd_data(rd_data), .tgt_addr(tgt_addr), .xfer_rd(xfer_rd),
        .addr10(addr10), .head10r_only(head10r_only), .nbytes(nbytes),
        .reload(reload), .autoend_eff(autoend_eff), .start_go(start_go),
        .stop_req(stop_req), .nack_req(nack_req), .pec_go(pec_go));

    // Each entry: {byte enables, write data, expected read-back}.
    localparam logic [67:0] VEC [NVEC] = '{
        {4'hF, 32'h0000_00A4, 32'h0000_00A4},  // R2 full write
        {4'h1, 32'h0000_0055, 32'h0000_0055},  // R2 byte 0 only
        {4'h4, 32'h0007_0000, 32'h0007_0055},  // R2 byte count
        {4'h2, 32'h0000_0C00, 32'h0007_0C55},  // R2 direction and 10-bit mode
        {4'h8, 32'hF800_0000, 32'h0007_0C55},  // R2 reserved bits read 0
        {4'h8, 32'h0300_0000, 32'h0307_0C55},  // R2 reload and auto-end
        {4'h2, 32'h0000_E000, 32'h0307_E055},  // R3 set start, stop, nack
        {4'hF, 32'h0000_0000, 32'h0007_E055},  // R3 and R8 zeros; lock held
        {4'h1, 32'h0000_00FF, 32'h0007_E055}   // R8 address write ignored
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply the current inputs for one clock edge, then idle them.
    task automatic tick();
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0;
        evt_addr_sent = 0; evt_arb_lost = 0; evt_timeout = 0; evt_addr_clr = 0;
        evt_nack_sent = 0; evt_pec_sent = 0; evt_stop_rx = 0; evt_addr_match = 0;
        periph_en = 1'b1;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rd_data", rd_data, 32'h0);
        check("R1 reset engine outputs",
              {22'd0, tgt_addr, start_go, stop_req, nack_req, pec_go,
               autoend_eff, reload, xfer_rd, addr10, head10r_only, |nbytes},
              32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            check($sformatf("R2 vector %0d", i), rd_data, VEC[i][31:0]);
        end

        // R4: address sent clears start only.
        evt_addr_sent = 1'b1; tick();
        check("R4 addr_sent clears start", rd_data, 32'h0007_C055);
        // R8 unlocked again; R9 7-bit normalisation.
        wr(4'h1, 32'h0000_00A4);
        check("R8 unlocked write", rd_data, 32'h0007_C0A4);
        check("R9 7-bit target", {22'd0, tgt_addr}, 32'h52);
        wr(4'h2, 32'h0000_0B00);
        check("R9 10-bit target", {22'd0, tgt_addr}, 32'h3A4);
        check("R3 zero write keeps stop/nack", rd_data, 32'h0007_CBA4);
        // R6, R5: stop received clears stop and nack.
        evt_stop_rx = 1'b1; tick();
        check("R6 R5 stop_rx clears", rd_data, 32'h0007_0BA4);
        // R5: pec set, masked by reload (R10), cleared by pec_sent.
        wr(4'h8, 32'h0400_0000);
        check("R10 pec_go without reload", {31'd0, pec_go}, 32'h1);
        wr(4'h8, 32'h0500_0000);
        check("R10 pec_go masked", {31'd0, pec_go}, 32'h0);
        evt_pec_sent = 1'b1; tick();
        check("R5 pec_sent clears pec", rd_data, 32'h0107_0BA4);
        // R10: start and auto-end masked by reload.
        wr(4'hA, 32'h0300_2B00);
        check("R10 start/autoend masked", {30'd0, start_go, autoend_eff}, 32'h0);
        wr(4'h8, 32'h0000_0000);
        check("R10 start_go unmasked", {31'd0, start_go}, 32'h1);
        // R4: timeout, address clear, peripheral disable.
        evt_timeout = 1'b1; tick();
        check("R4 timeout clears start", {31'd0, rd_data[13]}, 32'h0);
        wr(4'h2, 32'h0000_2B00);
        evt_addr_clr = 1'b1; tick();
        check("R4 addr_clr clears start", {31'd0, rd_data[13]}, 32'h0);
        // R7: same-cycle set and clear.
        evt_arb_lost = 1'b1; wr(4'h2, 32'h0000_2B00);
        check("R7 arb_lost beats start set", rd_data, 32'h0007_0BA4);
        evt_addr_match = 1'b1; wr(4'h2, 32'h0000_8B00);
        check("R7 addr_match beats nack set", rd_data, 32'h0007_0BA4);
        // R5: nack_sent clears nack.
        wr(4'h2, 32'h0000_8B00);
        evt_nack_sent = 1'b1; tick();
        check("R5 nack_sent clears nack", rd_data, 32'h0007_0BA4);
        // R4 R5 R6: disable clears every request flag.
        wr(4'hA, 32'h0400_EB00);
        check("R3 all flags set", rd_data, 32'h0407_EBA4);
        periph_en = 1'b0; tick();
        check("R4 R5 R6 disable clears", rd_data, 32'h0007_0BA4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule